// File: doc/BRIEF.md
# Single-Pin Tearing Sync Detector

This block watches the one tearing-effect line that a display panel drives back to its host. The panel uses that single wire for both line sync and frame sync and tells them apart only by how long each pulse lasts. The detector measures each pulse in ticks of a divided clock and labels it as a frame (vertical) pulse, a line (horizontal) pulse, or noise. It can then raise an interrupt pulse at a point in the frame where starting a frame-buffer write will not tear the image.

Two firing policies exist. The first fires on every frame pulse. The second counts line pulses after each frame pulse and fires once, on a chosen line. The interrupt is an active-low strobe one clock long, so a falling-edge interrupt input can consume it.

A control FSM with four states drives the decision:
- `S_IDLE`: detection is off.
- `S_WAIT_VS`: armed and waiting for a frame pulse.
- `S_COUNT`: counting lines toward the target.
- `S_DONE`: has fired for this frame.

The FSM makes these transitions:
- `S_IDLE` to `S_WAIT_VS` when the mode selects a firing policy.
- Any state to `S_IDLE` when the mode is off.
- `S_COUNT` or `S_DONE` to `S_WAIT_VS` when the policy changes to frame-only.
- `S_WAIT_VS`, `S_COUNT` or `S_DONE` to `S_COUNT` on a frame pulse in line mode.
- The same three states to `S_DONE` on a frame pulse in line mode when the target is 0.
- `S_COUNT` to `S_DONE` when the line count reaches the target.
- `S_WAIT_VS` back to itself on a frame pulse in frame-only mode, which fires.

Top module: `te_sync_detector`

## Requirements
- R1: After reset, `match_n` is 1 and no interrupt is produced until a qualifying pulse ends.
- R2: Pulse widths are measured in ticks of `clk` divided by `div_sel`+1, where `div_sel` is 3 bits (divide by 1 to 8).
- R3: A pulse whose width is at least (`vs_width`+1)*8 ticks is classified as vertical when it ends.
- R4: A pulse whose width is at least `hs_width`+1 ticks but below the vertical threshold is horizontal. A shorter pulse is ignored and is not counted as a line.
- R5: When `hs_inv` or `vs_inv` is 0, a pulse is a high level on `te_in` for that kind of detection. When the bit is 1, a pulse is a low level.
- R6: With `mode` equal to 0 (off) or 1 (reserved), no interrupt is produced.
- R7: With `mode` equal to 3, each vertical pulse produces exactly one interrupt, and horizontal pulses produce none.
- R8: With `mode` equal to 2, one interrupt is produced when the number of horizontal pulses since the last vertical pulse reaches `target_line` (11 bits). Further lines in that frame produce nothing.
- R9: With `mode` equal to 2 and `target_line` equal to 0, the vertical pulse itself produces the interrupt.
- R10: Each vertical pulse in mode 2 clears the line count and re-arms the detector for the next frame. The count saturates at 2047 instead of wrapping.
- R11: Each interrupt is `match_n` low for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_in | input | 1 | Tearing-effect line from the panel |
| div_sel | input | 3 | Tick divider minus one |
| hs_width | input | 3 | Horizontal threshold in ticks minus one |
| vs_width | input | 9 | Vertical threshold in units of 8 ticks, minus one |
| hs_inv | input | 1 | Invert the line for horizontal detection |
| vs_inv | input | 1 | Invert the line for vertical detection |
| mode | input | 2 | 0 off, 1 reserved (off), 2 line match, 3 frame only |
| target_line | input | 11 | Line number for mode 2 |
| match_n | output | 1 | Active-low one-cycle interrupt strobe |

## Verification
The hardest case to reach from the ports is line-count saturation together with a target at the top of the 11-bit range. That case needs 2047 well-formed horizontal pulses after a single vertical pulse. The stimulus produces it with a long run of short line pulses and checks that exactly one strobe appears at the last line. A second hard case separates noise from lines. Glitches shorter than the horizontal threshold are mixed into a counted frame, and the test shows that the strobe still falls on the right line.

// File: rtl/te_pkg.sv
package te_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_WAIT_VS = 2'd1,
        S_COUNT   = 2'd2,
        S_DONE    = 2'd3
    } te_state_t;

    localparam logic [1:0] MODE_OFF  = 2'd0;
    localparam logic [1:0] MODE_RSVD = 2'd1;
    localparam logic [1:0] MODE_LINE = 2'd2;
    localparam logic [1:0] MODE_VS   = 2'd3;
endpackage

// File: rtl/te_tick_div.sv
module te_tick_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < div_sel) |=> (cnt <= div_sel) || $changed(div_sel));
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    output logic             done,
    output logic [CNT_W-1:0] width
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             act_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt   <= '0;
            done  <= 1'b0;
            width <= '0;
        end else begin
            act_q <= active;
            done  <= 1'b0;
            if (act_q && !active) begin
                done  <= 1'b1;
                width <= cnt;
                cnt   <= '0;
            end else if (active && tick && cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0));
endmodule

// File: rtl/te_sync_detector.sv
module te_sync_detector
    import te_pkg::*;
#(
    parameter int DIV_W  = 3,
    parameter int HS_W   = 3,
    parameter int VS_W   = 9,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te_in,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [HS_W-1:0]   hs_width,
    input  logic [VS_W-1:0]   vs_width,
    input  logic              hs_inv,
    input  logic              vs_inv,
    input  logic [1:0]        mode,
    input  logic [LINE_W-1:0] target_line,
    output logic              match_n
);
    localparam int CNT_W = VS_W + 4;
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic             te_q, tick;
    logic             h_done, v_done;
    logic [CNT_W-1:0] h_w, v_w, hs_ticks, vs_ticks;
    logic             hs_evt, vs_evt;
    te_state_t        state, state_nx;
    logic [LINE_W-1:0] line_cnt, line_nx;
    logic             fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) te_q <= 1'b0;
        else        te_q <= te_in;
    end

    te_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(tick));

    te_pulse_meter #(.CNT_W(CNT_W)) u_hmeter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .active(te_q ^ hs_inv),
        .done(h_done), .width(h_w));

    te_pulse_meter #(.CNT_W(CNT_W)) u_vmeter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .active(te_q ^ vs_inv),
        .done(v_done), .width(v_w));

    assign hs_ticks = CNT_W'(hs_width) + 1'b1;
    assign vs_ticks = (CNT_W'(vs_width) + 1'b1) << 3;
    assign vs_evt   = v_done && (v_w >= vs_ticks);
    assign hs_evt   = h_done && (h_w >= hs_ticks) && (h_w < vs_ticks);

    always_comb begin
        state_nx = state;
        line_nx  = line_cnt;
        fire     = 1'b0;
        if (mode == MODE_OFF || mode == MODE_RSVD) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: state_nx = S_WAIT_VS;
                S_WAIT_VS, S_COUNT, S_DONE: begin
                    if (mode == MODE_VS) begin
                        state_nx = S_WAIT_VS;
                        if (state == S_WAIT_VS && vs_evt) fire = 1'b1;
                    end else if (vs_evt) begin
                        line_nx = '0;
                        if (target_line == '0) begin
                            fire     = 1'b1;
                            state_nx = S_DONE;
                        end else begin
                            state_nx = S_COUNT;
                        end
                    end else if (hs_evt && state != S_WAIT_VS) begin
                        if (line_cnt != LINE_MAX) line_nx = line_cnt + 1'b1;
                        if (state == S_COUNT && line_nx == target_line) begin
                            fire     = 1'b1;
                            state_nx = S_DONE;
                        end
                    end
                end
                default: state_nx = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_n  <= 1'b1;
            line_cnt <= '0;
        end else begin
            match_n  <= !fire;
            line_cnt <= line_nx;
        end
    end

    // R4
    class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hs_evt, vs_evt}));

    // R6
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF || mode == MODE_RSVD) |=> match_n);

    // R11
    match_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_n |=> match_n);

    // R10
    line_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt == LINE_MAX && !vs_evt) |=> (line_cnt == LINE_MAX));

    // R10
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_evt && mode == MODE_LINE && state != S_IDLE) |=> (line_cnt == '0));
endmodule

// File: tb/tb_te_sync_detector.sv
module tb_te_sync_detector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        te_in = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic [2:0]  hs_width = 3'd3;
    logic [8:0]  vs_width = 9'd1;
    logic        hs_inv = 1'b0, vs_inv = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [10:0] target_line = 11'd0;
    logic        match_n;

    int checks = 0, fails = 0;
    int hits = 0, low_run = 0, max_run = 0;
    int cycles = 0;
    logic idle_lvl = 1'b0;

    te_sync_detector dut (
        .clk(clk), .rst_n(rst_n), .te_in(te_in), .div_sel(div_sel),
        .hs_width(hs_width), .vs_width(vs_width), .hs_inv(hs_inv),
        .vs_inv(vs_inv), .mode(mode), .target_line(target_line),
        .match_n(match_n));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !match_n) begin
            low_run++;
            if (low_run == 1) hits++;
            if (low_run > max_run) max_run = low_run;
        end else begin
            low_run = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int len, input int gap);
        @(negedge clk) te_in = !idle_lvl;
        repeat (len) @(negedge clk);
        te_in = idle_lvl;
        repeat (gap) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] m, input int tgt);
        @(negedge clk);
        mode = 2'd0;
        repeat (3) @(negedge clk);
        target_line = 11'(tgt);
        mode = m;
        repeat (3) @(negedge clk);
        hits = 0;
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        check("R1 reset match_n", int'(match_n), 1);
        check("R1 no strobe", hits, 0);
    endtask

    task automatic t_mode_vs;
        setup(2'd3, 0);
        pulse(30, 10);
        check("R7 vs fires once", hits, 1);
        pulse(8, 10);
        check("R7 hs ignored", hits, 1);
        check("R11 one cycle low", max_run, 1);
        pulse(30, 10);
        check("R7 next vs fires", hits, 2);
    endtask

    task automatic t_mode_off;
        setup(2'd0, 0);
        pulse(30, 10);
        check("R6 mode0 silent", hits, 0);
        setup(2'd1, 0);
        pulse(30, 10);
        check("R6 mode1 silent", hits, 0);
    endtask

    task automatic t_line;
        setup(2'd2, 3);
        pulse(30, 10);
        pulse(8, 8);
        pulse(8, 8);
        check("R8 before target", hits, 0);
        pulse(8, 8);
        check("R8 at target", hits, 1);
        pulse(8, 8);
        check("R8 once per frame", hits, 1);
        pulse(30, 10);
        pulse(8, 8);
        pulse(8, 8);
        pulse(8, 8);
        check("R10 rearm after vs", hits, 2);
    endtask

    task automatic t_short;
        setup(2'd2, 2);
        pulse(30, 10);
        pulse(2, 8);
        pulse(8, 8);
        pulse(2, 8);
        check("R4 glitch ignored", hits, 0);
        pulse(8, 8);
        check("R4 fires on real line", hits, 1);
    endtask

    task automatic t_target0;
        setup(2'd2, 0);
        pulse(8, 8);
        check("R9 hs no fire", hits, 0);
        pulse(30, 10);
        check("R9 fires on vs", hits, 1);
    endtask

    task automatic t_polarity;
        idle_lvl = 1'b1;
        hs_inv = 1'b1;
        vs_inv = 1'b1;
        @(negedge clk) te_in = 1'b1;
        setup(2'd3, 0);
        pulse(30, 10);
        check("R5 inverted vs", hits, 1);
        setup(2'd2, 1);
        pulse(30, 10);
        pulse(8, 8);
        check("R5 inverted hs", hits, 1);
        idle_lvl = 1'b0;
        hs_inv = 1'b0;
        vs_inv = 1'b0;
        @(negedge clk) te_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_divider;
        div_sel = 3'd3;
        setup(2'd3, 0);
        pulse(30, 20);
        check("R2 30 cyc is hs at div4", hits, 0);
        pulse(100, 20);
        check("R3 100 cyc is vs at div4", hits, 1);
        div_sel = 3'd0;
        vs_width = 9'd3;
        setup(2'd3, 0);
        pulse(24, 10);
        check("R3 below 32 ticks", hits, 0);
        pulse(40, 10);
        check("R3 above 32 ticks", hits, 1);
        vs_width = 9'd1;
    endtask

    task automatic t_max_line;
        setup(2'd2, 2047);
        pulse(30, 10);
        for (int i = 0; i < 2046; i++) pulse(6, 5);
        check("R10 before line 2047", hits, 0);
        pulse(6, 5);
        check("R10 fires line 2047", hits, 1);
        for (int i = 0; i < 4; i++) pulse(6, 5);
        check("R10 saturated no refire", hits, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode_vs();
        t_mode_off();
        t_line();
        t_short();
        t_target0();
        t_polarity();
        t_divider();
        t_max_line();
        check("R11 max low run", max_run, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule